// File: doc/BRIEF.md
# Root-Port Event Interrupt Aggregator

This block collects the interrupt-worthy events of a PCIe root-port bridge into one 32-bit latched status word and presents a single level-sensitive interrupt line to the CPU. It accepts the following inputs, all as single-cycle pulses:

- a completion-timeout event;
- five message events: power-management event received, turn-off acknowledge received, correctable error, non-fatal error and fatal error;
- assert and deassert indications for each of the four legacy INTx lines.

Software reaches the block through a plain register port: address, write data, write strobe, read strobe and read data. Software reads the status word and clears latched events by writing ones to them. It never writes the mask directly. One register turns mask bits on and another turns them off. In both, only the ones in the written word act. This lets independent handlers mask and unmask their own sources without a read-modify-write race.

The output interrupt is registered. It is high whenever a latched status bit is set and its mask bit is clear, one cycle after that condition arises.

Top module: `irq_event_agg`

## Requirements
- R1: After reset, the status word reads 0x00000000, the mask word reads 0x1FFF8000 (every defined source masked), and `irq_o` is 0.
- R2: A pulse on `cpl_timeout_i` sets status bit 15. Pulses on `msg_evt_i[k]` set status bit 24+k: k=0 PME received, k=1 turn-off acknowledge, k=2 correctable, k=3 non-fatal, k=4 fatal. Each bit is set at the clock edge where its pulse is sampled high.
- R3: A pulse on `intx_assert_i[n]` sets status bit 16+2n, and a pulse on `intx_deassert_i[n]` sets status bit 17+2n, for n = 0 to 3.
- R4: A write to the status register (offset 0x4C0) clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R5: If a source pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to the enable register (offset 0x4C8) clears, on the next clock, each mask bit written as 1. Bits written as 0 keep their value.
- R7: A write to the disable register (offset 0x4CC) sets, on the next clock, each defined mask bit written as 1. Bits written as 0 keep their value.
- R8: `irq_o` equals, one cycle later, the OR over all bits of status AND NOT mask.
- R9: Status bits 0 to 14 and 29 to 31, and the same mask bits, always read as 0. A write to the mask register (offset 0x4C4) changes nothing. `rdata_o` is 0 when `rd_i` is low or the address matches none of 0x4C0, 0x4C4, 0x4C8, 0x4CC; the enable and disable offsets read as 0.
- R10: With `rd_i` high, `rdata_o` shows the status word at 0x4C0 and the mask word at 0x4C4 in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid while `rd_i` is high |
| cpl_timeout_i | input | 1 | Completion-timeout event pulse |
| msg_evt_i | input | 5 | Message event pulses (PME, turn-off ack, correctable, non-fatal, fatal) |
| intx_assert_i | input | 4 | INTx line assert pulses |
| intx_deassert_i | input | 4 | INTx line deassert pulses |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
Assertions check the following on every cycle:
- any sampled source pulse leaves its status bit set on the next cycle, even under a clear;
- a status bit only drops after a write-one clear of that bit;
- enable and disable writes move exactly the bits they name;
- the mask holds still when neither register is written;
- `irq_o` only rises after some status bit was set.

Only the bench's scenarios show the rest:
- the exact bit positions of each source, including the interleaved INTx assert and deassert positions;
- the reset values;
- that writes to the mask offset and zero bits in writes have no effect;
- the one-cycle output latency against a reference model under long random mixes of traffic.

// File: rtl/irq_event_agg_pkg.sv
package irq_event_agg_pkg;
   localparam int unsigned WORD_W = 32;

   // Build a bit vector with ones over [lo, lo+cnt).
   function automatic logic [WORD_W-1:0] span_bits(input int unsigned lo, input int unsigned cnt);
      logic [WORD_W-1:0] v;
      v = '0;
      for (int unsigned i = 0; i < WORD_W; i++) begin
         if (i >= lo && i < lo + cnt) v[i] = 1'b1;
      end
      return v;
   endfunction
endpackage

// File: rtl/irq_event_srcmap.sv
module irq_event_srcmap
   import irq_event_agg_pkg::*;
#(
   parameter int unsigned CTO_POS    = 15,
   parameter int unsigned INTX_BASE  = 16,
   parameter int unsigned INTX_LINES = 4,
   parameter int unsigned MSG_BASE   = 24,
   parameter int unsigned NUM_MSG    = 5
) (
   input  logic                  cpl_timeout_i,
   input  logic [NUM_MSG-1:0]    msg_evt_i,
   input  logic [INTX_LINES-1:0] intx_assert_i,
   input  logic [INTX_LINES-1:0] intx_deassert_i,
   output logic [WORD_W-1:0]     set_o
);
   initial begin
      if (CTO_POS >= INTX_BASE) $error("completion-timeout position overlaps INTx field");
      if (INTX_BASE + 2*INTX_LINES > MSG_BASE) $error("INTx field overlaps message field");
      if (MSG_BASE + NUM_MSG > WORD_W) $error("message field exceeds word");
   end

   logic [WORD_W-1:0] intx_v, msg_v, cto_v;

   // Interleaved INTx: assert at even offset, deassert at odd offset.
   for (genvar n = 0; n < WORD_W; n++) begin : g_bit
      if (n >= INTX_BASE && n < INTX_BASE + 2*INTX_LINES) begin : g_intx
         if (((n - INTX_BASE) % 2) == 0) begin : g_as
            assign intx_v[n] = intx_assert_i[(n - INTX_BASE)/2];
         end else begin : g_de
            assign intx_v[n] = intx_deassert_i[(n - INTX_BASE)/2];
         end
      end else begin : g_nointx
         assign intx_v[n] = 1'b0;
      end
      if (n >= MSG_BASE && n < MSG_BASE + NUM_MSG) begin : g_msg
         assign msg_v[n] = msg_evt_i[n - MSG_BASE];
      end else begin : g_nomsg
         assign msg_v[n] = 1'b0;
      end
      if (n == CTO_POS) begin : g_cto
         assign cto_v[n] = cpl_timeout_i;
      end else begin : g_nocto
         assign cto_v[n] = 1'b0;
      end
   end

   assign set_o = intx_v | msg_v | cto_v;
endmodule

// File: rtl/irq_event_status.sv
module irq_event_status
   import irq_event_agg_pkg::*;
#(
   parameter logic [WORD_W-1:0] VALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_i,
   input  logic [WORD_W-1:0] clr_i,
   output logic [WORD_W-1:0] status_o
);
   logic [WORD_W-1:0] status_q;

   // New events override a same-cycle clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= ((status_q & ~clr_i) | set_i) & VALID;
   end

   assign status_o = status_q;

   // R5
   set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & VALID) != '0) |=> ((status_q & $past(set_i & VALID)) == $past(set_i & VALID)));
   // R4
   drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_event_mask.sv
module irq_event_mask
   import irq_event_agg_pkg::*;
#(
   parameter logic [WORD_W-1:0] VALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] en_i,
   input  logic [WORD_W-1:0] dis_i,
   output logic [WORD_W-1:0] mask_o
);
   logic [WORD_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= VALID;
      else        mask_q <= ((mask_q & ~en_i) | dis_i) & VALID;
   end

   assign mask_o = mask_q;

   // R6
   enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i != '0 && dis_i == '0) |=> ((mask_q & $past(en_i)) == '0));
   // R7
   disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dis_i & VALID) != '0) |=> ((mask_q & $past(dis_i & VALID)) == $past(dis_i & VALID)));
   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i == '0 && dis_i == '0) |=> $stable(mask_q));
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
   import irq_event_agg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned STAT_OFF   = 12'h4C0,
   parameter int unsigned MASK_OFF   = 12'h4C4,
   parameter int unsigned EN_OFF     = 12'h4C8,
   parameter int unsigned DIS_OFF    = 12'h4CC,
   parameter int unsigned CTO_POS    = 15,
   parameter int unsigned INTX_BASE  = 16,
   parameter int unsigned INTX_LINES = 4,
   parameter int unsigned MSG_BASE   = 24,
   parameter int unsigned NUM_MSG    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [WORD_W-1:0]     wdata_i,
   input  logic                  wr_i,
   input  logic                  rd_i,
   output logic [WORD_W-1:0]     rdata_o,
   input  logic                  cpl_timeout_i,
   input  logic [NUM_MSG-1:0]    msg_evt_i,
   input  logic [INTX_LINES-1:0] intx_assert_i,
   input  logic [INTX_LINES-1:0] intx_deassert_i,
   output logic                  irq_o
);
   localparam logic [WORD_W-1:0] VALID =
      span_bits(CTO_POS, 1) | span_bits(INTX_BASE, 2*INTX_LINES) | span_bits(MSG_BASE, NUM_MSG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFF);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFF);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFF);
   localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(DIS_OFF);

   initial begin
      if (STAT_OFF == MASK_OFF || EN_OFF == DIS_OFF || STAT_OFF == EN_OFF || STAT_OFF == DIS_OFF
          || MASK_OFF == EN_OFF || MASK_OFF == DIS_OFF)
         $error("register offsets must be distinct");
      if (DIS_OFF >= (1 << ADDR_W)) $error("offset beyond address width");
   end

   logic [WORD_W-1:0] set_vec, clr_vec, en_vec, dis_vec, status_w, mask_w;
   logic              irq_q;

   irq_event_srcmap #(
      .CTO_POS(CTO_POS), .INTX_BASE(INTX_BASE), .INTX_LINES(INTX_LINES),
      .MSG_BASE(MSG_BASE), .NUM_MSG(NUM_MSG)
   ) u_srcmap (
      .cpl_timeout_i(cpl_timeout_i), .msg_evt_i(msg_evt_i),
      .intx_assert_i(intx_assert_i), .intx_deassert_i(intx_deassert_i),
      .set_o(set_vec)
   );

   assign clr_vec = (wr_i && addr_i == A_STAT) ? wdata_i : '0;
   assign en_vec  = (wr_i && addr_i == A_EN)   ? (wdata_i & VALID) : '0;
   assign dis_vec = (wr_i && addr_i == A_DIS)  ? (wdata_i & VALID) : '0;

   irq_event_status #(.VALID(VALID)) u_status (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .status_o(status_w)
   );

   irq_event_mask #(.VALID(VALID)) u_mask (
      .clk(clk), .rst_n(rst_n), .en_i(en_vec), .dis_i(dis_vec), .mask_o(mask_w)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         if (addr_i == A_STAT)      rdata_o = status_w;
         else if (addr_i == A_MASK) rdata_o = mask_w;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_w & ~mask_w);
   end

   assign irq_o = irq_q;

   // R8
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(status_w) != '0));
   // R8
   irq_masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask_w) == VALID) |-> !irq_o);
endmodule

// File: tb/irq_event_agg_tb.sv
module irq_event_agg_tb;
   localparam logic [31:0] VALID = 32'h1FFF_8000;
   localparam logic [11:0] A_ST = 12'h4C0, A_MK = 12'h4C4, A_EN = 12'h4C8, A_DI = 12'h4CC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] rdata;
   logic        cto = 1'b0;
   logic [4:0]  msg = '0;
   logic [3:0]  ia = '0, id = '0;
   logic        irq;

   int checks = 0, fails = 0;
   logic done = 1'b0;

   logic [31:0] m_st, m_mk;
   logic        m_irq;

   always #2 clk = ~clk;

   irq_event_agg u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
      .rdata_o(rdata), .cpl_timeout_i(cto), .msg_evt_i(msg), .intx_assert_i(ia),
      .intx_deassert_i(id), .irq_o(irq)
   );

   function automatic logic [31:0] src_bits(input logic c, input logic [4:0] m,
                                            input logic [3:0] a, input logic [3:0] d);
      logic [31:0] v = '0;
      v[15] = c;
      for (int k = 0; k < 5; k++) v[24+k] = m[k];
      for (int n = 0; n < 4; n++) begin
         v[16+2*n] = a[n];
         v[17+2*n] = d[n];
      end
      return v;
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      if (a == A_ST) return m_st;
      if (a == A_MK) return m_mk;
      return 32'h0;
   endfunction

   // Reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= '0; m_mk <= VALID; m_irq <= 1'b0;
      end else begin
         m_irq <= |(m_st & ~m_mk);
         m_st  <= ((m_st & ~((wr && addr == A_ST) ? wdata : 32'h0)) | src_bits(cto, msg, ia, id)) & VALID;
         if (wr && addr == A_EN) m_mk <= m_mk & ~wdata & VALID;
         else if (wr && addr == A_DI) m_mk <= (m_mk | wdata) & VALID;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // R8: output compared every cycle
   always @(negedge clk) begin
      if (rst_n && !done) check("R8 irq", {31'b0, irq}, {31'b0, m_irq});
   end

   task automatic cyc(input logic [11:0] a, input logic [31:0] d, input logic w,
                      input logic c, input logic [4:0] m, input logic [3:0] x, input logic [3:0] y);
      @(negedge clk);
      addr = a; wdata = d; wr = w; rd = 1'b0; cto = c; msg = m; ia = x; id = y;
      @(posedge clk);
      #1;
      wr = 1'b0; cto = 1'b0; msg = '0; ia = '0; id = '0;
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a; rd = 1'b1; wr = 1'b0;
      #1;
      check(tag, rdata, exp);
      @(posedge clk);
      #1;
      rd = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset values
      rdchk("R1 status", A_ST, 32'h0);
      rdchk("R1 mask", A_MK, 32'h1FFF_8000);
      check("R1 irq", {31'b0, irq}, 32'h0);
      // R9 no read strobe / unmapped
      @(negedge clk); addr = A_MK; rd = 1'b0; #1; check("R9 no rd", rdata, 32'h0);
      rdchk("R9 enable offset reads 0", A_EN, 32'h0);
      rdchk("R9 unmapped", 12'h4D0, 32'h0);
      // R2 positions
      cyc(A_ST, 0, 0, 1'b1, 5'b0, 4'b0, 4'b0);
      rdchk("R2 cto bit15", A_ST, 32'h0000_8000);
      for (int k = 0; k < 5; k++) begin
         cyc(A_ST, 32'hFFFF_FFFF, 1, 1'b0, 5'b0, 4'b0, 4'b0);
         cyc(A_ST, 0, 0, 1'b0, 5'(1 << k), 4'b0, 4'b0);
         rdchk("R2 msg bit", A_ST, 32'h1 << (24 + k));
      end
      // R3 interleaved INTx
      for (int n = 0; n < 4; n++) begin
         cyc(A_ST, 32'hFFFF_FFFF, 1, 1'b0, 5'b0, 4'b0, 4'b0);
         cyc(A_ST, 0, 0, 1'b0, 5'b0, 4'(1 << n), 4'b0);
         rdchk("R3 assert", A_ST, 32'h1 << (16 + 2*n));
         cyc(A_ST, 0, 0, 1'b0, 5'b0, 4'b0, 4'(1 << n));
         rdchk("R3 deassert", A_ST, (32'h1 << (16 + 2*n)) | (32'h1 << (17 + 2*n)));
      end
      // R4 partial clear
      cyc(A_ST, 0, 0, 1'b1, 5'h1F, 4'hF, 4'hF);
      cyc(A_ST, 32'h0100_8000, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R4 partial clear", A_ST, 32'h1EFF_0000);
      // R5 set wins
      cyc(A_ST, 32'h1000_0000, 1, 1'b0, 5'b10000, 4'b0, 4'b0);
      rdchk("R5 set beats clear", A_ST, 32'h1EFF_0000);
      // R6 / R7 mask control
      cyc(A_EN, 32'h0001_0000, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R6 enable one bit", A_MK, 32'h1FFE_8000);
      check("R8 irq after unmask", {31'b0, irq}, 32'h1);
      cyc(A_EN, 32'h0, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R6 zero write", A_MK, 32'h1FFE_8000);
      cyc(A_MK, 32'h0, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R9 mask write ignored", A_MK, 32'h1FFE_8000);
      cyc(A_DI, 32'hE001_0000, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R7 disable", A_MK, 32'h1FFF_8000);
      cyc(A_DI, 32'h0, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R7 zero write", A_MK, 32'h1FFF_8000);
      cyc(A_EN, 32'hFFFF_FFFF, 1, 1'b0, 5'b0, 4'b0, 4'b0);
      rdchk("R9 undefined bits 0", A_MK, 32'h0);
      rdchk("R10 status readback", A_ST, 32'h1EFF_0000);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int op;
         logic [31:0] d;
         logic [11:0] a;
         op = $urandom_range(0, 5);
         d  = $urandom();
         case (op)
            0: a = A_ST;
            1: a = A_EN;
            2: a = A_DI;
            3: a = A_MK;
            default: a = ($urandom_range(0, 1) != 0) ? A_ST : A_MK;
         endcase
         if (op >= 4) rdchk("R10 random read", a, exp_read(a));
         else cyc(a, d, 1'b1, ($urandom_range(0, 7) == 0), 5'($urandom() & $urandom()),
                  4'($urandom() & $urandom()), 4'($urandom() & $urandom()));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule